// File: doc/BRIEF.md
# DES Round Coprocessor

This unit sits beside a 32-bit processor core and runs the Data Encryption Standard one round at a time. Software reaches it through two plain ports: a register-write port that fills four 32-bit state registers, and a read port that returns any of them. Two registers hold the key halves and two hold the data halves. A single round request moves the cipher forward by one full Feistel round in one clock cycle. Sixteen requests finish a block, and software then reads the result from the two data registers.

The key is loaded as two words. The high word goes to the first key register, where it waits. Writing the low word to the second key register runs the 64-to-56-bit key compression on the pair. This replaces both key registers with their 28-bit halves, resets the round counter and captures the encrypt/decrypt selection. The data block is written raw. The initial permutation is applied inside the first round request and the final permutation inside the sixteenth, so the core needs no separate permutation operations.

Both directions use the same round hardware. Decryption walks the sub-keys backwards by rotating the key halves to the right instead of the left. After sixteen rounds in either direction the key registers hold the values they had just after the load. Further blocks under the same key therefore need only a fresh data load.

Top module: `des_round_unit`

## Requirements
- R1: After reset all four state registers read as zero.
- R2: Writing address 0 stores the raw high key word. Writing address 1 with the low word then replaces addresses 0 and 1 with the two 28-bit halves of the key compression permutation of the 64-bit key (first half to address 0). Bits 31:28 of both read as zero, and the least significant bit of every key byte has no effect on any result.
- R3: With encryption selected, sixteen round requests after loading a key (addresses 0, 1) and a block (high word at address 2, low word at address 3) leave the standard DES ciphertext at addresses 2 (high) and 3 (low).
- R4: The encrypt/decrypt input (1 = decrypt) is captured only on the write to address 1. With decrypt captured, sixteen rounds turn a ciphertext back into its plaintext.
- R5: After sixteen rounds in either direction the key registers return to their post-load values and the round counter is back at its start. A following block loaded without a key reload gives the same result as with a reload.
- R6: Cycles with neither a write nor a round request change no state, so idle gaps between round requests do not alter the result.
- R7: When a write and a round request arrive in the same cycle, the write takes effect and the round request is dropped.
- R8: Encrypting the bitwise complement of a block under the complemented key yields the complement of the ciphertext.
- R9: The read port returns the register chosen by its select: 0 and 1 are the key halves, 2 and 3 are the high and low data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 key high, 1 key low/commit, 2 data high, 3 data low |
| wr_data | input | 32 | Write data |
| key_decrypt | input | 1 | Direction, captured on a write to address 1 (1 = decrypt) |
| round_go | input | 1 | Request one cipher round |
| rd_sel | input | 2 | Read address, same encoding as wr_sel |
| rd_data | output | 32 | Selected register contents |

## Verification
The checker assumes software follows the load order. The high key word comes before the low word, no round request falls between them, and a block gets exactly sixteen rounds after its data load before the data registers are rewritten. The key compression, the zeroed upper key bits, the counter wrap and the held direction bit are checked against that order. The bench builds every access from tasks that keep to this order. Its one deliberate exception, a write that collides with a round request, is still a complete data rewrite, so the checked sequence stays valid. Random keys and blocks come from a fixed seed and are checked through round trips and the complement property. Published answer vectors and known key halves pin down absolute correctness.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 28;
    localparam int SUBK_W  = 48;
    localparam int BLOCK_W = 2 * WORD_W;
    localparam int CNT_W   = 4;
    localparam int N_SBOX  = 8;

    localparam int P_TAB [32] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

    localparam int PC1_TAB [56] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

    localparam int PC2_TAB [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    // Each box: 64 nibbles, row-major (row = outer bits, column = inner bits).
    localparam logic [255:0] SBOX_TAB [N_SBOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

    typedef struct packed {
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] l;
        logic [WORD_W-1:0] r;
        logic [CNT_W-1:0]  cnt;
        logic              dec;
    } des_state_t;

    // Source position (1-based from MSB) of output bit i of the initial permutation.
    function automatic int ip_src(input int i);
        int row;
        int col;
        row = i / 8;
        col = i % 8;
        return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
    endfunction

    function automatic logic [63:0] ip_perm(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[63 - i] = x[64 - ip_src(i)];
        return y;
    endfunction

    function automatic logic [63:0] fp_perm(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[64 - ip_src(i)] = x[63 - i];
        return y;
    endfunction

    function automatic logic [47:0] e_expand(input logic [31:0] x);
        logic [47:0] y;
        for (int i = 0; i < 48; i++) y[47 - i] = x[31 - ((4 * (i / 6) + (i % 6) + 31) % 32)];
        return y;
    endfunction

    function automatic logic [31:0] p_perm(input logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[31 - i] = x[32 - P_TAB[i]];
        return y;
    endfunction

    function automatic logic [55:0] pc1_perm(input logic [63:0] x);
        logic [55:0] y;
        for (int i = 0; i < 56; i++) y[55 - i] = x[64 - PC1_TAB[i]];
        return y;
    endfunction

    function automatic logic [47:0] pc2_perm(input logic [55:0] x);
        logic [47:0] y;
        for (int i = 0; i < 48; i++) y[47 - i] = x[56 - PC2_TAB[i]];
        return y;
    endfunction

    function automatic logic [3:0] sbox_look(input int box, input logic [5:0] x);
        int idx;
        idx = 16 * int'({x[5], x[0]}) + int'(x[4:1]);
        return SBOX_TAB[box][255 - 4 * idx -: 4];
    endfunction

endpackage

// File: rtl/des_key_step.sv
module des_key_step
    import des_pkg::*;
(
    input  logic [HALF_W-1:0] c_cur,
    input  logic [HALF_W-1:0] d_cur,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dec,
    output logic [SUBK_W-1:0] subkey,
    output logic [HALF_W-1:0] c_nxt,
    output logic [HALF_W-1:0] d_nxt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << CNT_W) - 1);

    logic [1:0]        amt;
    logic [HALF_W-1:0] c_use;
    logic [HALF_W-1:0] d_use;

    function automatic logic [HALF_W-1:0] rot(input logic [HALF_W-1:0] x,
                                              input logic [1:0] n, input logic right);
        logic [2*HALF_W-1:0] dbl;
        dbl = {x, x};
        if (right) return dbl[HALF_W-1 + 32'(n) -: HALF_W];
        return dbl[2*HALF_W-1 - 32'(n) -: HALF_W];
    endfunction

    always_comb begin
        if (cnt == '0 || cnt == CNT_W'(1) || cnt == CNT_W'(8) || cnt == LAST)
            amt = 2'd1;
        else
            amt = 2'd2;
        if (dec && cnt == '0)
            amt = 2'd0;
        c_use  = rot(c_cur, amt, dec);
        d_use  = rot(d_cur, amt, dec);
        subkey = pc2_perm({c_use, d_use});
        // decrypt walks 27 places over 16 rounds; one more restores the load value
        c_nxt  = (dec && cnt == LAST) ? rot(c_use, 2'd1, 1'b1) : c_use;
        d_nxt  = (dec && cnt == LAST) ? rot(d_use, 2'd1, 1'b1) : d_use;
    end

endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import des_pkg::*;
(
    input  logic [WORD_W-1:0] r_in,
    input  logic [SUBK_W-1:0] subkey,
    output logic [WORD_W-1:0] f_out
);

    logic [SUBK_W-1:0] mixed;
    logic [WORD_W-1:0] sub_out;

    assign mixed = e_expand(r_in) ^ subkey;

    for (genvar g = 0; g < N_SBOX; g++) begin : g_box
        assign sub_out[WORD_W-1 - 4*g -: 4] = sbox_look(g, mixed[SUBK_W-1 - 6*g -: 6]);
    end

    assign f_out = p_perm(sub_out);

endmodule

// File: rtl/des_round_unit.sv
module des_round_unit
    import des_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              key_decrypt,
    input  logic              round_go,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [1:0]       SEL_C = 2'd0;
    localparam logic [1:0]       SEL_D = 2'd1;
    localparam logic [1:0]       SEL_L = 2'd2;
    localparam logic [1:0]       SEL_R = 2'd3;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'((1 << CNT_W) - 1);
    localparam int               PAD_W = WORD_W - HALF_W;

    des_state_t st_q, st_d;

    logic [BLOCK_W-1:0] lr_in;
    logic [WORD_W-1:0]  l_in, r_in, f_val;
    logic [SUBK_W-1:0]  subkey;
    logic [HALF_W-1:0]  c_nxt, d_nxt;
    logic [2*HALF_W-1:0] halves;

    // Signals observed by the bound checker
    logic [WORD_W-1:0]  c_q, d_q, l_q, r_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               dec_q;
    assign c_q   = st_q.c;
    assign d_q   = st_q.d;
    assign l_q   = st_q.l;
    assign r_q   = st_q.r;
    assign cnt_q = st_q.cnt;
    assign dec_q = st_q.dec;

    assign lr_in = (st_q.cnt == '0) ? ip_perm({st_q.l, st_q.r}) : {st_q.l, st_q.r};
    assign l_in  = lr_in[BLOCK_W-1:WORD_W];
    assign r_in  = lr_in[WORD_W-1:0];

    des_key_step u_key (
        .c_cur  (st_q.c[HALF_W-1:0]),
        .d_cur  (st_q.d[HALF_W-1:0]),
        .cnt    (st_q.cnt),
        .dec    (st_q.dec),
        .subkey (subkey),
        .c_nxt  (c_nxt),
        .d_nxt  (d_nxt)
    );

    des_feistel u_f (
        .r_in   (r_in),
        .subkey (subkey),
        .f_out  (f_val)
    );

    always_comb begin
        st_d   = st_q;
        halves = pc1_perm({st_q.c, wr_data});
        if (wr_en) begin
            unique case (wr_sel)
                SEL_C: st_d.c = wr_data;
                SEL_D: begin
                    st_d.c   = {{PAD_W{1'b0}}, halves[2*HALF_W-1:HALF_W]};
                    st_d.d   = {{PAD_W{1'b0}}, halves[HALF_W-1:0]};
                    st_d.cnt = '0;
                    st_d.dec = key_decrypt;
                end
                SEL_L: st_d.l = wr_data;
                SEL_R: st_d.r = wr_data;
                default: ;
            endcase
        end else if (round_go) begin
            if (st_q.cnt == LAST) begin
                {st_d.l, st_d.r} = fp_perm({l_in ^ f_val, r_in});
            end else begin
                st_d.l = r_in;
                st_d.r = l_in ^ f_val;
            end
            st_d.c   = {{PAD_W{1'b0}}, c_nxt};
            st_d.d   = {{PAD_W{1'b0}}, d_nxt};
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_C:   rd_data = st_q.c;
            SEL_D:   rd_data = st_q.d;
            SEL_L:   rd_data = st_q.l;
            default: rd_data = st_q.r;
        endcase
    end

endmodule

// File: rtl/des_round_unit_chk.sv
module des_round_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        round_go,
    input logic [3:0]  cnt_q,
    input logic        dec_q,
    input logic [31:0] c_q,
    input logic [31:0] d_q,
    input logic [31:0] l_q,
    input logic [31:0] r_q
);

    a_r2_key_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd1 |=> cnt_q == 4'd0 && c_q[31:28] == 4'd0 && d_q[31:28] == 4'd0);

    a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> $stable(dec_q));

    a_r5_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && round_go && cnt_q == 4'd15 |=> cnt_q == 4'd0);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !round_go |=> $stable(c_q) && $stable(d_q) && $stable(l_q)
                                && $stable(r_q) && $stable(cnt_q));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel != 2'd1 |=> cnt_q == $past(cnt_q));

    a_r3_half_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && round_go && cnt_q != 4'd0 && cnt_q != 4'd15 |=> l_q == $past(r_q));

endmodule

bind des_round_unit des_round_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .round_go (round_go),
    .cnt_q    (cnt_q),
    .dec_q    (dec_q),
    .c_q      (c_q),
    .d_q      (d_q),
    .l_q      (l_q),
    .r_q      (r_q)
);

// File: tb/tb_des_round_unit.sv
module tb_des_round_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        key_decrypt = 1'b0;
    logic        round_go = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    des_round_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .key_decrypt(key_decrypt), .round_go(round_go), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%016h expected=%016h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] v, input logic dec);
        wr_en = 1'b1; wr_sel = s; wr_data = v; key_decrypt = dec;
        @(negedge clk);
        wr_en = 1'b0; key_decrypt = 1'b0;
    endtask

    task automatic rnd();
        round_go = 1'b1;
        @(negedge clk);
        round_go = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1 v = rd_data;
    endtask

    task automatic load_key(input logic [63:0] k, input logic dec);
        wr(2'd0, k[63:32], 1'b0);
        wr(2'd1, k[31:0], dec);
    endtask

    task automatic load_blk(input logic [63:0] b);
        wr(2'd2, b[63:32], 1'b0);
        wr(2'd3, b[31:0], 1'b0);
    endtask

    task automatic run16(input int gap);
        for (int i = 0; i < 16; i++) begin
            rnd();
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic read_blk(output logic [63:0] b);
        logic [31:0] hi, lo;
        rd(2'd2, hi);
        rd(2'd3, lo);
        b = {hi, lo};
    endtask

    task automatic cipher(input logic [63:0] k, input logic [63:0] b, input logic dec,
                          output logic [63:0] res);
        load_key(k, dec);
        load_blk(b);
        run16(0);
        read_blk(res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] res, res2, k, p, c;
        logic [31:0] w;
        int unsigned sd;
        sd = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), w);
            check("R1 reset reg", {32'd0, w}, 64'd0);
        end

        // R9 / R2: raw high key word visible before commit
        wr(2'd0, 32'h13345779, 1'b0);
        rd(2'd0, w);
        check("R9 raw key high word", {32'd0, w}, 64'h13345779);
        wr(2'd1, 32'h9BBCDFF1, 1'b0);
        rd(2'd0, w);
        check("R2 first key half", {32'd0, w}, 64'h0F0CCAAF);
        rd(2'd1, w);
        check("R2 second key half", {32'd0, w}, 64'h0556678F);
        load_blk(64'h0123456789ABCDEF);
        read_blk(res);
        check("R9 data words", res, 64'h0123456789ABCDEF);
        run16(0);
        read_blk(res);
        check("R3 known answer 1", res, 64'h85E813540F0AB405);
        rd(2'd0, w);
        check("R5 key half restored enc", {32'd0, w}, 64'h0F0CCAAF);

        cipher(64'h0E329232EA6D0D73, 64'h8787878787878787, 1'b0, res);
        check("R3 known answer 2", res, 64'h0000000000000000);
        cipher(64'h0, 64'h0, 1'b0, res);
        check("R3 known answer 3", res, 64'h8CA64DE9C1B123A7);

        cipher(64'h133457799BBCDFF1, 64'h85E813540F0AB405, 1'b1, res);
        check("R4 decrypt known answer", res, 64'h0123456789ABCDEF);
        rd(2'd1, w);
        check("R5 key half restored dec", {32'd0, w}, 64'h0556678F);
        cipher(64'h0E329232EA6D0D73, 64'h0, 1'b1, res);
        check("R4 decrypt known answer 2", res, 64'h8787878787878787);

        // R2: parity bits ignored
        cipher(64'h133457799BBCDFF1 ^ 64'h0101010101010101, 64'h0123456789ABCDEF, 1'b0, res);
        check("R2 parity bits ignored", res, 64'h85E813540F0AB405);

        // R6: idle gaps
        load_key(64'h133457799BBCDFF1, 1'b0);
        load_blk(64'h0123456789ABCDEF);
        run16(3);
        read_blk(res);
        check("R6 idle gaps", res, 64'h85E813540F0AB405);

        // R7: write collides with round request at round 0 and at round 5
        load_key(64'h133457799BBCDFF1, 1'b0);
        load_blk(64'h0123456789ABCDEF);
        round_go = 1'b1;
        wr(2'd3, 32'h89ABCDEF, 1'b0);
        round_go = 1'b0;
        run16(0);
        read_blk(res);
        check("R7 write wins at round 0", res, 64'h85E813540F0AB405);
        load_key(64'h133457799BBCDFF1, 1'b0);
        load_blk(64'h0123456789ABCDEF);
        run16(0);
        load_blk(64'h0123456789ABCDEF);
        round_go = 1'b1;
        wr(2'd2, 32'h01234567, 1'b0);
        round_go = 1'b0;
        run16(0);
        read_blk(res);
        check("R7 write wins after block", res, 64'h85E813540F0AB405);

        // Random keys and blocks
        for (int n = 0; n < 24; n++) begin
            k = {$urandom, $urandom};
            p = {$urandom, $urandom};
            cipher(k, p, 1'b0, c);
            cipher(k, c, 1'b1, res);
            check("R4 random round trip", res, p);
            cipher(~k, ~p, 1'b0, res);
            check("R8 complement property", res, ~c);
            // R5: second block without key reload, encrypt then decrypt
            load_key(k, 1'b0);
            load_blk(~p);
            run16(n % 3);
            load_blk(p);
            run16(0);
            read_blk(res2);
            check("R5 reuse key encrypt", res2, c);
            load_key(k, 1'b1);
            load_blk(64'h0);
            run16(0);
            load_blk(c);
            run16(0);
            read_blk(res2);
            check("R5 reuse key decrypt", res2, p);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule